// File: doc/BRIEF.md
# Magic-Sequence Watchdog with Reset Cause

This block is a watchdog timer with a small register bus. Once software enables it, it counts cycles on which a tick enable input is high. If the count completes a programmed power-of-two period, it raises a reset request. Software keeps the system alive by writing two fixed 32-bit magic words, in a strict order, to two keepalive registers. Any break in that sequence raises a reset request at once. Turning the watchdog off is also protected. Clearing the enable bit only takes effect when a complete, valid keepalive pair follows it.

Every reset request also stores a 3-bit cause code. The request can come from a timeout, a broken keepalive, a software write to the soft-reset register, or the user-reset pin. The cause register is cleared only by the power-on reset input, so it keeps its value through the system reset that the request itself triggers. Software reads the cause back from the first keepalive register.

Top module: `magic_watchdog`

## Requirements
- R1: After power-on reset, `rstReq` is 0, the configuration register reads 0, and the cause field reads 0 (hard reset).
- R2: The configuration register sits at byte offset 0x04. Bit 31 is the enable bit and bits 4:0 are the delay selector. A read returns exactly those bits, and every other bit reads 0. Offsets 0x00 and 0x0C read as 0.
- R3: Writing the configuration register with bit 31 set, while the watchdog is stopped, starts the count from zero. The period is 2^(delay+1) tick cycles. On the edge that takes the final tick, `rstReq` goes high for one cycle, cause code 1 (timeout) is stored, and the count restarts. While the watchdog is stopped, no timeout request occurs.
- R4: The count advances only on cycles where `tickEn` is 1.
- R5: A valid keepalive pair clears the count to zero, so the next timeout comes a full period after the edge of the second write. A valid pair is 0xABCD1234 written to offset 0x08, followed by 0x4321DCBA written to offset 0x0C.
- R6: Each of the following raises `rstReq` on the next cycle and stores cause code 2: a value other than 0xABCD1234 written to 0x08; a value other than 0x4321DCBA written to 0x0C; a write to 0x0C without a correct 0x08 write before it since the last 0x0C write. A correct 0x08 write on its own raises nothing.
- R7: After the enable bit is written as 0, the count keeps running and timeouts still occur. The watchdog stops only when the next valid keepalive pair arrives.
- R8: A write of any value to offset 0x00 raises `rstReq` on the next cycle and stores cause code 3.
- R9: `userRstIn` high at an edge raises `rstReq` on the next cycle and stores cause code 4. When several causes occur in the same cycle, the priority is user (4), then soft (3), then keepalive error (2), then timeout (1).
- R10: Reading offset 0x08 returns the cause code in bits 2:0, and the other bits read 0. The cause survives `sysRstN` and is cleared to 0 only by `porRstN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low; clears everything including the cause |
| sysRstN | input | 1 | System reset, active low; clears all state except the cause |
| tickEn | input | 1 | Watchdog tick enable; the count advances on cycles where it is high |
| userRstIn | input | 1 | User reset request pin |
| busAddr | input | 4 | Byte address of the register access |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write strobe, one write per cycle it is high |
| busRdata | output | 32 | Read data for `busAddr` (combinational) |
| rstReq | output | 1 | Registered reset request pulse |

## Verification
Reset requests from a bus write or from the user pin are registered, so they are due on the cycle right after the edge that samples the stimulus. The stored cause is readable from that same cycle. A timeout is due exactly 2^(delay+1) tick-edges after the edge that enabled the watchdog or accepted the second keepalive word. The bench therefore checks that the request is still low one edge before that point, high at it, and low again one edge after. The bench drives every input at the falling edge and samples at the next falling edge. It counts edges and ticks itself, so each expected moment comes from the requirement arithmetic and not from the design.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 32;
  localparam int DELAY_W  = 5;
  localparam int CAUSE_W  = 3;

  localparam logic [ADDR_W-1:0] ADDR_SOFT = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_KA1  = 4'h8;
  localparam logic [ADDR_W-1:0] ADDR_KA2  = 4'hC;

  localparam logic [DATA_W-1:0] MAGIC_FIRST  = 32'hABCD_1234;
  localparam logic [DATA_W-1:0] MAGIC_SECOND = 32'h4321_DCBA;

  localparam logic [CAUSE_W-1:0] CAUSE_HARD    = 3'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_TIMEOUT = 3'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_BADKICK = 3'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_SOFT    = 3'd3;
  localparam logic [CAUSE_W-1:0] CAUSE_USER    = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntRun;
    logic evBad;
    logic evSoft;
    logic evUser;
  } wdtStrobes_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic                busWe,
  input  logic                userRstIn,
  output wdtStrobes_t         strobes,
  output logic                cfgEn,
  output logic [DELAY_W-1:0]  cfgDelay,
  output logic                running
);
  logic armed;
  logic wrSoft, wrCfg, wrKa1, wrKa2;
  logic ka1Ok, ka1Bad, pairOk, ka2Bad;
  logic unusedBits;

  assign wrSoft = busWe && (busAddr == ADDR_SOFT);
  assign wrCfg  = busWe && (busAddr == ADDR_CFG);
  assign wrKa1  = busWe && (busAddr == ADDR_KA1);
  assign wrKa2  = busWe && (busAddr == ADDR_KA2);

  assign ka1Ok  = wrKa1 && (busWdata == MAGIC_FIRST);
  assign ka1Bad = wrKa1 && !ka1Ok;
  assign pairOk = wrKa2 && armed && (busWdata == MAGIC_SECOND);
  assign ka2Bad = wrKa2 && !pairOk;

  assign unusedBits = ^busWdata[DATA_W-2:DELAY_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEn    <= 1'b0;
      cfgDelay <= '0;
      armed    <= 1'b0;
      running  <= 1'b0;
    end else begin
      if (wrCfg) begin
        cfgEn    <= busWdata[DATA_W-1];
        cfgDelay <= busWdata[DELAY_W-1:0];
      end
      if (ka1Ok)
        armed <= 1'b1;
      else if (ka1Bad || wrKa2)
        armed <= 1'b0;
      if (wrCfg && busWdata[DATA_W-1])
        running <= 1'b1;
      else if (pairOk && !cfgEn)
        running <= 1'b0;
    end
  end

  always_comb begin
    strobes.cntClear = pairOk || (wrCfg && busWdata[DATA_W-1] && !running);
    strobes.cntRun   = running;
    strobes.evBad    = ka1Bad || ka2Bad;
    strobes.evSoft   = wrSoft;
    strobes.evUser   = userRstIn;
  end
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                porRstN,
  input  logic                tickEn,
  input  wdtStrobes_t         strobes,
  input  logic [DELAY_W-1:0]  cfgDelay,
  output logic [CAUSE_W-1:0]  causeCode,
  output logic                rstReq
);
  localparam int CNT_W = (1 << DELAY_W) + 1;

  logic [CNT_W-1:0]   count;
  logic [CNT_W-1:0]   termVal;
  logic [DELAY_W:0]   shAmt;
  logic               timeoutHit;
  logic               anyEv;
  logic [CAUSE_W-1:0] nextCause;

  assign shAmt      = {1'b0, cfgDelay} + (DELAY_W+1)'(1);
  assign termVal    = (CNT_W'(1) << shAmt) - CNT_W'(1);
  assign timeoutHit = strobes.cntRun && tickEn && (count == termVal);
  assign anyEv      = strobes.evUser || strobes.evSoft || strobes.evBad || timeoutHit;

  always_comb begin
    if (strobes.evUser)      nextCause = CAUSE_USER;
    else if (strobes.evSoft) nextCause = CAUSE_SOFT;
    else if (strobes.evBad)  nextCause = CAUSE_BADKICK;
    else                     nextCause = CAUSE_TIMEOUT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      rstReq <= 1'b0;
    end else begin
      rstReq <= anyEv;
      if (strobes.cntClear || anyEv)
        count <= '0;
      else if (strobes.cntRun && tickEn)
        count <= count + CNT_W'(1);
    end
  end

  // sticky cause: only power-on reset clears it
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)
      causeCode <= CAUSE_HARD;
    else if (anyEv)
      causeCode <= nextCause;
  end
endmodule

// File: rtl/magic_watchdog.sv
module magic_watchdog
  import wdt_pkg::*;
(
  input  logic               clk,
  input  logic               porRstN,
  input  logic               sysRstN,
  input  logic               tickEn,
  input  logic               userRstIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic               busWe,
  output logic [DATA_W-1:0]  busRdata,
  output logic               rstReq
);
  wdtStrobes_t         strobes;
  logic                cfgEn;
  logic [DELAY_W-1:0]  cfgDelay;
  logic                running;
  logic [CAUSE_W-1:0]  causeCode;
  logic                rstN;

  assign rstN = porRstN & sysRstN;

  wdt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .userRstIn(userRstIn), .strobes(strobes),
    .cfgEn(cfgEn), .cfgDelay(cfgDelay), .running(running)
  );

  wdt_datapath u_dp (
    .clk(clk), .rstN(rstN), .porRstN(porRstN), .tickEn(tickEn),
    .strobes(strobes), .cfgDelay(cfgDelay), .causeCode(causeCode),
    .rstReq(rstReq)
  );

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_CFG)
      busRdata = {cfgEn, {(DATA_W-1-DELAY_W){1'b0}}, cfgDelay};
    else if (busAddr == ADDR_KA1)
      busRdata = {{(DATA_W-CAUSE_W){1'b0}}, causeCode};
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
(
  input logic               clk,
  input logic               porRstN,
  input logic               sysRstN,
  input logic               userRstIn,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic               busWe,
  input logic               rstReq,
  input logic [CAUSE_W-1:0] causeCode,
  input logic               running
);
  assert_soft_req_R8: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    (busWe && busAddr == ADDR_SOFT && !userRstIn) |=> (rstReq && causeCode == CAUSE_SOFT));

  assert_bad_first_R6: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    (busWe && busAddr == ADDR_KA1 && busWdata != MAGIC_FIRST && !userRstIn)
      |=> (rstReq && causeCode == CAUSE_BADKICK));

  assert_user_req_R9: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    userRstIn |=> (rstReq && causeCode == CAUSE_USER));

  assert_cause_sticky_R10: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    !$stable(causeCode) |-> rstReq);

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    (!running && !busWe && !userRstIn) |=> !rstReq);
endmodule

bind magic_watchdog wdt_checker u_chk (
  .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .userRstIn(userRstIn),
  .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe), .rstReq(rstReq),
  .causeCode(causeCode), .running(running)
);

// File: tb/sim_magic_watchdog.sv
`timescale 1ns/1ps
module sim_magic_watchdog;
  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        sysRstN = 1'b0;
  logic        tickEn = 1'b1;
  logic        userRstIn = 1'b0;
  logic [3:0]  busAddr = 4'h0;
  logic [31:0] busWdata = 32'h0;
  logic        busWe = 1'b0;
  logic [31:0] busRdata;
  logic        rstReq;
  int checks = 0;
  int errors = 0;

  localparam logic [31:0] M1 = 32'hABCD_1234;
  localparam logic [31:0] M2 = 32'h4321_DCBA;

  magic_watchdog u0 (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .tickEn(tickEn),
    .userRstIn(userRstIn), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRdata(busRdata), .rstReq(rstReq)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write sampled at the rising edge between two falling edges
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic sysReset();
    @(negedge clk);
    sysRstN = 1'b0;
    repeat (2) @(negedge clk);
    sysRstN = 1'b1;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int p;
    int ticks;
    bit hit;
    repeat (3) @(negedge clk);
    porRstN = 1'b1; sysRstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rstReq", {31'b0, rstReq}, 32'd0);
    rd(4'h4, v); check("R1 config", v, 32'd0);
    rd(4'h8, v); check("R1 cause", v, 32'd0);

    // R2 config readback
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, v); check("R2 config all ones", v, 32'h8000_001F);
    wr(4'h4, 32'h7FFF_FFEA);
    rd(4'h4, v); check("R2 config mixed", v, 32'h0000_000A);
    rd(4'h0, v); check("R2 soft reads 0", v, 32'd0);
    rd(4'hC, v); check("R2 ka2 reads 0", v, 32'd0);
    sysReset();

    // R3 period sweep, enable from stopped starts at zero
    for (int d = 0; d < 5; d++) begin
      p = 1 << (d + 1);
      tickEn = 1'b1;
      wr(4'h4, 32'h8000_0000 | d);
      for (int k = 1; k <= p + 1; k++) begin
        @(negedge clk);
        if (k == p - 1) check("R3 before period", {31'b0, rstReq}, 32'd0);
        if (k == p)     check("R3 at period", {31'b0, rstReq}, 32'd1);
        if (k == p + 1) check("R3 one-cycle pulse", {31'b0, rstReq}, 32'd0);
      end
      rd(4'h8, v); check("R3 cause timeout", v, 32'd1);
      sysReset();
      rd(4'h8, v); check("R10 cause survives sysRstN", v, 32'd1);
    end

    // R4 tick gating: delay 2, period 8 ticks
    p = 8; ticks = 0; hit = 0;
    wr(4'h4, 32'h8000_0002);
    for (int c = 0; c < 60 && !hit; c++) begin
      logic expReq;
      tickEn = (c % 3) != 0;
      expReq = tickEn && (ticks == p - 1);
      if (tickEn) ticks++;
      @(negedge clk);
      check("R4 gated timeout", {31'b0, rstReq}, {31'b0, expReq});
      if (expReq) hit = 1;
    end
    check("R4 timeout reached", {31'b0, hit}, 32'd1);
    tickEn = 1'b1;
    sysReset();

    // R5 valid pair clears the count: delay 3, period 16
    p = 16;
    wr(4'h4, 32'h8000_0003);
    waitEdges(10);
    wr(4'h8, M1);
    check("R5 first word no request", {31'b0, rstReq}, 32'd0);
    wr(4'hC, M2);
    check("R5 pair no request", {31'b0, rstReq}, 32'd0);
    for (int k = 1; k <= p; k++) begin
      @(negedge clk);
      if (k == p - 1) check("R5 before period", {31'b0, rstReq}, 32'd0);
      if (k == p)     check("R5 full period after pair", {31'b0, rstReq}, 32'd1);
    end
    sysReset();

    // R7 disable takes effect only after a valid pair: delay 2, period 8
    p = 8;
    wr(4'h4, 32'h8000_0002);
    wr(4'h4, 32'h0000_0002);
    rd(4'h4, v); check("R7 enable reads 0", v, 32'h0000_0002);
    waitEdges(p - 2);
    check("R7 still counting", {31'b0, rstReq}, 32'd1);
    wr(4'h8, M1);
    wr(4'hC, M2);
    hit = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (rstReq) hit = 1;
    end
    check("R7 stopped after pair", {31'b0, hit}, 32'd0);

    // R6 bad keepalive cases
    wr(4'h0, 32'h0);
    wr(4'h8, 32'h1);
    check("R6 wrong first word req", {31'b0, rstReq}, 32'd1);
    rd(4'h8, v); check("R6 wrong first word cause", v, 32'd2);
    wr(4'h0, 32'h0);
    wr(4'hC, M2);
    check("R6 unarmed second word req", {31'b0, rstReq}, 32'd1);
    rd(4'h8, v); check("R6 unarmed cause", v, 32'd2);
    wr(4'h0, 32'h0);
    wr(4'h8, M1);
    wr(4'hC, 32'h0);
    check("R6 wrong second word req", {31'b0, rstReq}, 32'd1);
    rd(4'h8, v); check("R6 wrong second cause", v, 32'd2);
    wr(4'h0, 32'h0);
    wr(4'h8, M1);
    check("R6 correct first word alone", {31'b0, rstReq}, 32'd0);
    wr(4'hC, M2);
    wr(4'hC, M2);
    check("R6 repeated second word", {31'b0, rstReq}, 32'd1);

    // R8 soft reset
    wr(4'h0, 32'h5A5A_0000);
    check("R8 soft req", {31'b0, rstReq}, 32'd1);
    rd(4'h8, v); check("R8 soft cause", v, 32'd3);
    @(negedge clk);
    check("R8 pulse ends", {31'b0, rstReq}, 32'd0);

    // R9 user pin and priority
    @(negedge clk);
    userRstIn = 1'b1;
    @(negedge clk);
    userRstIn = 1'b0;
    check("R9 user req", {31'b0, rstReq}, 32'd1);
    rd(4'h8, v); check("R9 user cause", v, 32'd4);
    wr(4'h0, 32'h0);
    @(negedge clk);
    busAddr = 4'h8; busWdata = 32'h0; busWe = 1'b1; userRstIn = 1'b1;
    @(negedge clk);
    busWe = 1'b0; userRstIn = 1'b0;
    check("R9 user over bad req", {31'b0, rstReq}, 32'd1);
    rd(4'h8, v); check("R9 user wins priority", v, 32'd4);

    // R10 cause sticky through sysRstN, cleared by porRstN
    sysReset();
    rd(4'h8, v); check("R10 cause after sysRstN", v, 32'd4);
    @(negedge clk);
    porRstN = 1'b0;
    repeat (2) @(negedge clk);
    porRstN = 1'b1;
    @(negedge clk);
    rd(4'h8, v); check("R10 cause after porRstN", v, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule